// File: doc/BRIEF.md
# Power-Mode Control and Status Register

This block holds the operating-mode control and status register of a system basis chip. A small register bus, fed by an external serial shifter, reaches it at address `0x0B`. A write to that address carries a 3-bit mode command. The command moves the chip between debug, normal, standby, stop and sleep operation. A read from the same address returns four status flags and clears the two flags that latch. The analog comparators and the bus transceiver fault detectors sit outside the block. Each of their results arrives as a single asynchronous bit and passes through a two-flop synchronizer before the block uses it.

The block refuses a sleep command unless two conditions hold: the battery-fail flag is already clear, and the no-stop bit of the companion reset-control register is set. While the chip is in stop, the watchdog-enable output follows the stop-watchdog bit of that companion register. The current mode is available as a one-hot vector.

Requests use a valid/ready handshake. Only reads produce a response, which also uses valid/ready. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low only while a response is waiting that the consumer has not yet taken. While `rsp_valid` is high and `rsp_ready` is low, the response holds steady and no new request is accepted.

Top module: `pmode_ctrl_reg`

## Requirements
- R1: Either reset input going low (power-on or external) puts the block into normal mode and clears all four flags. After reset, `rsp_valid` is 0 and `wd_enable` is 1.
- R2: An accepted write to address 0x0B takes its command from `req_wdata[2:0]`. Command 001 selects normal, 010 selects standby, and both 100 and 101 select stop. The new mode appears on the clock edge that accepts the write. `mode_onehot` always has exactly one bit set, with this bit map: [0] debug, [1] normal, [2] standby, [3] stop, [4] sleep.
- R3: Command 000 moves the block from any mode other than debug into debug. When the block is already in debug, command 000 returns it to normal.
- R4: Command 110 enters sleep only when the battery-fail flag is 0 and `rcr_nostop` is 1. When either condition fails, the mode does not change.
- R5: The block ignores reserved commands 011 and 111, and it ignores writes to any other address. In both cases the mode stays the same.
- R6: `wd_enable` is 1 in normal and standby and 0 in debug and sleep. In stop it equals `rcr_stop_wd`.
- R7: A read of 0x0B returns the flags in `rsp_rdata` one clock edge after acceptance, with this bit map: [3] general failure, [2] regulator temperature warning, [1] watchdog reset, [0] battery fail. A read of any other address returns 0 and clears nothing.
- R8: The battery-fail flag is set while the synchronized `supply_low` input is high, and a write can never set it. A read of 0x0B clears it, except that the set wins when `supply_low` is still high in the same cycle.
- R9: A pulse on `wd_reset_evt` latches the watchdog-reset flag. A read of 0x0B clears the flag.
- R10: The general-failure flag is the live OR of the five fault inputs. The temperature-warning flag is the live value of `vdd_temp_warn`. Neither flag latches.
- R11: While `rsp_valid` is 1 and `rsp_ready` is 0, `req_ready` is 0, no request takes effect, and `rsp_rdata` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| ext_rst_n | input | 1 | External reset, active low, asynchronous |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Register address |
| req_wdata | input | 4 | Write data; bits 2:0 carry the command |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Read response ready |
| rsp_rdata | output | 4 | Read data (status flags) |
| supply_low | input | 1 | Supply below 3.0 V, asynchronous |
| wd_reset_evt | input | 1 | Watchdog reset occurred, asynchronous |
| can_tx_dom | input | 1 | Transmit line stuck dominant |
| can_overcur | input | 1 | Transceiver overcurrent |
| can_therm | input | 1 | Transceiver thermal fault |
| hs1_overtemp | input | 1 | High-side switch 1 overtemperature |
| v2_low | input | 1 | Second regulator undervoltage |
| vdd_temp_warn | input | 1 | Main regulator temperature pre-warning |
| rcr_nostop | input | 1 | Companion register no-stop bit |
| rcr_stop_wd | input | 1 | Companion register stop-watchdog bit |
| mode_onehot | output | 5 | Current mode, one-hot |
| wd_enable | output | 1 | Watchdog enable |

## Verification
Three things can meet on one clock edge: the read that clears the battery-fail flag, a still-active supply-low condition that sets it, and a sleep command whose guard reads that flag. The bench holds `supply_low` high across two back-to-back reads. Both reads must return the flag set, since the set overrides the clear. A sleep command issued while the flag is set must leave the mode unchanged. Only after the input drops and a clearing read returns 1 does a later read return 0, and only then is sleep accepted.

// File: rtl/pmode_pkg.sv
package pmode_pkg;

  localparam int MODE_N = 5;
  localparam int FLAG_N = 4;
  localparam int CMD_W  = 3;

  typedef enum logic [2:0] {
    MD_DEBUG   = 3'd0,
    MD_NORMAL  = 3'd1,
    MD_STANDBY = 3'd2,
    MD_STOP    = 3'd3,
    MD_SLEEP   = 3'd4
  } pmode_e;

  localparam logic [CMD_W-1:0] CMD_DEBUG   = 3'b000;
  localparam logic [CMD_W-1:0] CMD_NORMAL  = 3'b001;
  localparam logic [CMD_W-1:0] CMD_STANDBY = 3'b010;
  localparam logic [CMD_W-1:0] CMD_STOP_A  = 3'b100;
  localparam logic [CMD_W-1:0] CMD_STOP_B  = 3'b101;
  localparam logic [CMD_W-1:0] CMD_SLEEP   = 3'b110;

  localparam int BIT_BATFAIL = 0;
  localparam int BIT_WDRST   = 1;
  localparam int BIT_VTEMP   = 2;
  localparam int BIT_GFAIL   = 3;

  localparam int FAULT_N = 5;

endpackage

// File: rtl/pmode_sync.sv
module pmode_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);

  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= d_async;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[s] <= '0;
      else        stg[s] <= stg[s-1];
    end
  end

  assign q_sync = stg[STAGES-1];

endmodule

// File: rtl/pmode_status.sv
module pmode_status
  import pmode_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sup_low_s,
  input  logic               wd_evt_s,
  input  logic [FAULT_N-1:0] faults_s,
  input  logic               vtemp_s,
  input  logic               rd_clr,
  output logic [FLAG_N-1:0]  flags
);

  logic batfail_q;
  logic wdrst_q;
  logic gfail_q;
  logic vtemp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      batfail_q <= 1'b0;
      wdrst_q   <= 1'b0;
      gfail_q   <= 1'b0;
      vtemp_q   <= 1'b0;
    end else begin
      // hardware set has priority over the read clear
      if (sup_low_s)   batfail_q <= 1'b1;
      else if (rd_clr) batfail_q <= 1'b0;
      if (wd_evt_s)    wdrst_q   <= 1'b1;
      else if (rd_clr) wdrst_q   <= 1'b0;
      gfail_q <= |faults_s;
      vtemp_q <= vtemp_s;
    end
  end

  always_comb begin
    flags              = '0;
    flags[BIT_BATFAIL] = batfail_q;
    flags[BIT_WDRST]   = wdrst_q;
    flags[BIT_VTEMP]   = vtemp_q;
    flags[BIT_GFAIL]   = gfail_q;
  end

  p_batfail_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sup_low_s |=> flags[BIT_BATFAIL]);

  p_batfail_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[BIT_BATFAIL] && !rd_clr) |=> flags[BIT_BATFAIL]);

  p_wdrst_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wd_evt_s |=> flags[BIT_WDRST]);

  p_wdrst_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[BIT_WDRST] && !rd_clr) |=> flags[BIT_WDRST]);

endmodule

// File: rtl/pmode_mode_fsm.sv
module pmode_mode_fsm
  import pmode_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_vld,
  input  logic [CMD_W-1:0]  cmd,
  input  logic              batfail,
  input  logic              nostop,
  input  logic              stop_wd,
  output logic [MODE_N-1:0] mode_oh,
  output logic              wd_enable
);

  pmode_e cur_q;
  pmode_e nxt;

  always_comb begin
    nxt = cur_q;
    if (cmd_vld) begin
      unique case (cmd)
        CMD_DEBUG:   nxt = (cur_q == MD_DEBUG) ? MD_NORMAL : MD_DEBUG;
        CMD_NORMAL:  nxt = MD_NORMAL;
        CMD_STANDBY: nxt = MD_STANDBY;
        CMD_STOP_A,
        CMD_STOP_B:  nxt = MD_STOP;
        CMD_SLEEP:   nxt = (!batfail && nostop) ? MD_SLEEP : cur_q;
        default:     nxt = cur_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur_q <= MD_NORMAL;
    else        cur_q <= nxt;
  end

  for (genvar m = 0; m < MODE_N; m++) begin : g_onehot
    assign mode_oh[m] = (cur_q == pmode_e'(m));
  end

  always_comb begin
    unique case (cur_q)
      MD_NORMAL, MD_STANDBY: wd_enable = 1'b1;
      MD_STOP:               wd_enable = stop_wd;
      default:               wd_enable = 1'b0;
    endcase
  end

  p_mode_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(mode_oh) == 1);

  p_sleep_guard_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode_oh[MD_SLEEP]) |-> $past(!batfail && nostop && cmd_vld));

  p_idle_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_vld |=> $stable(mode_oh));

  p_wd_off_debug_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_oh[MD_DEBUG] || mode_oh[MD_SLEEP]) |-> !wd_enable);

endmodule

// File: rtl/pmode_ctrl_reg.sv
module pmode_ctrl_reg
  import pmode_pkg::*;
#(
  parameter int          ADDR_W   = 8,
  parameter logic [7:0]  REG_ADDR = 8'h0B,
  parameter int          SYNC_STG = 2
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              ext_rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [FLAG_N-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [FLAG_N-1:0] rsp_rdata,
  input  logic              supply_low,
  input  logic              wd_reset_evt,
  input  logic              can_tx_dom,
  input  logic              can_overcur,
  input  logic              can_therm,
  input  logic              hs1_overtemp,
  input  logic              v2_low,
  input  logic              vdd_temp_warn,
  input  logic              rcr_nostop,
  input  logic              rcr_stop_wd,
  output logic [MODE_N-1:0] mode_onehot,
  output logic              wd_enable
);

  localparam int SYNC_W = FAULT_N + 3;

  logic rst_n;
  assign rst_n = por_n & ext_rst_n;

  logic [SYNC_W-1:0] raw_in;
  logic [SYNC_W-1:0] syn_in;

  assign raw_in = {vdd_temp_warn, wd_reset_evt, supply_low,
                   v2_low, hs1_overtemp, can_therm, can_overcur, can_tx_dom};

  pmode_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STG)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (raw_in),
    .q_sync  (syn_in)
  );

  logic accept;
  logic hit;
  logic rd_clr;
  logic wr_cmd;
  logic [FLAG_N-1:0] flags;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign hit       = (req_addr == REG_ADDR[ADDR_W-1:0]);
  assign rd_clr    = accept && !req_write && hit;
  assign wr_cmd    = accept && req_write && hit;

  pmode_status u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .sup_low_s (syn_in[FAULT_N]),
    .wd_evt_s  (syn_in[FAULT_N+1]),
    .faults_s  (syn_in[FAULT_N-1:0]),
    .vtemp_s   (syn_in[FAULT_N+2]),
    .rd_clr    (rd_clr),
    .flags     (flags)
  );

  pmode_mode_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_vld   (wr_cmd),
    .cmd       (req_wdata[CMD_W-1:0]),
    .batfail   (flags[BIT_BATFAIL]),
    .nostop    (rcr_nostop),
    .stop_wd   (rcr_stop_wd),
    .mode_oh   (mode_onehot),
    .wd_enable (wd_enable)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (accept && !req_write) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= hit ? flags : '0;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  p_rsp_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  p_read_resp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write) |=> rsp_valid);

endmodule

// File: tb/pmode_ctrl_reg_bench.sv
`timescale 1ns/1ps
module pmode_ctrl_reg_bench;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       por_n = 1'b0, ext_rst_n = 1'b1;
  logic       req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [7:0] req_addr = 8'h0B;
  logic [3:0] req_wdata = 4'h0;
  logic       supply_low = 1'b0, wd_reset_evt = 1'b0, vdd_temp_warn = 1'b0;
  logic [4:0] faults = 5'b0;
  logic       rcr_nostop = 1'b0, rcr_stop_wd = 1'b0;
  logic       req_ready, rsp_valid, wd_enable;
  logic [3:0] rsp_rdata;
  logic [4:0] mode_onehot;

  pmode_ctrl_reg u_pmode_ctrl_reg (
    .clk(clk), .por_n(por_n), .ext_rst_n(ext_rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .supply_low(supply_low), .wd_reset_evt(wd_reset_evt),
    .can_tx_dom(faults[0]), .can_overcur(faults[1]), .can_therm(faults[2]),
    .hs1_overtemp(faults[3]), .v2_low(faults[4]),
    .vdd_temp_warn(vdd_temp_warn), .rcr_nostop(rcr_nostop),
    .rcr_stop_wd(rcr_stop_wd), .mode_onehot(mode_onehot), .wd_enable(wd_enable)
  );

  localparam logic [4:0] M_DBG = 5'b00001, M_NRM = 5'b00010, M_STB = 5'b00100,
                         M_STP = 5'b01000, M_SLP = 5'b10000;

  // {cmd[2:0], nostop, stop_wd, expected mode[4:0], expected wd}
  localparam int NVEC = 11;
  localparam logic [10:0] VEC [NVEC] = '{
    {3'b010, 1'b0, 1'b0, M_STB, 1'b1},
    {3'b100, 1'b0, 1'b1, M_STP, 1'b1},
    {3'b101, 1'b0, 1'b0, M_STP, 1'b0},
    {3'b011, 1'b0, 1'b0, M_STP, 1'b0},
    {3'b110, 1'b0, 1'b0, M_STP, 1'b0},
    {3'b000, 1'b0, 1'b0, M_DBG, 1'b0},
    {3'b000, 1'b0, 1'b0, M_NRM, 1'b1},
    {3'b000, 1'b0, 1'b0, M_DBG, 1'b0},
    {3'b110, 1'b1, 1'b0, M_SLP, 1'b0},
    {3'b111, 1'b1, 1'b0, M_SLP, 1'b0},
    {3'b001, 1'b0, 1'b0, M_NRM, 1'b1}
  };

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [3:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [3:0] d, output logic v);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    d = rsp_rdata; v = rsp_valid;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin : main
    logic [3:0] rd;
    logic       rv;
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 mode", {3'b0, mode_onehot}, {3'b0, M_NRM});
    check("R1 wd", {7'b0, wd_enable}, 8'd1);
    check("R1 rsp_valid", {7'b0, rsp_valid}, 8'd0);
    bus_read(8'h0B, rd, rv);
    check("R1 flags", {4'b0, rd}, 8'h0);
    check("R7 rsp_valid", {7'b0, rv}, 8'd1);

    // R2 R3 R4 R5 R6 vector walk
    for (int i = 0; i < NVEC; i++) begin
      rcr_nostop  = VEC[i][7];
      rcr_stop_wd = VEC[i][6];
      bus_write(8'h0B, {1'b0, VEC[i][10:8]});
      check($sformatf("R2/R3/R4/R5 vec%0d mode", i), {3'b0, mode_onehot}, {3'b0, VEC[i][5:1]});
      check($sformatf("R6 vec%0d wd", i), {7'b0, wd_enable}, {7'b0, VEC[i][0]});
    end

    // R6 stop watchdog follows companion bit live
    bus_write(8'h0B, 4'b0100);
    rcr_stop_wd = 1'b1; #1;
    check("R6 stop wd on", {7'b0, wd_enable}, 8'd1);
    rcr_stop_wd = 1'b0; #1;
    check("R6 stop wd off", {7'b0, wd_enable}, 8'd0);
    bus_write(8'h0B, 4'b0001);

    // R8 battery fail set; set wins over read clear; sleep refused
    supply_low = 1'b1; settle();
    rcr_nostop = 1'b1;
    bus_write(8'h0B, 4'b0110);
    check("R4 sleep refused batfail", {3'b0, mode_onehot}, {3'b0, M_NRM});
    bus_read(8'h0B, rd, rv);
    check("R8 batfail set", {4'b0, rd}, 8'h1);
    bus_read(8'h0B, rd, rv);
    check("R8 set wins over clear", {4'b0, rd}, 8'h1);
    supply_low = 1'b0; settle();
    bus_read(8'h0B, rd, rv);
    check("R8 still latched", {4'b0, rd}, 8'h1);
    bus_read(8'h0B, rd, rv);
    check("R8 cleared by read", {4'b0, rd}, 8'h0);
    bus_write(8'h0B, 4'b0110);
    check("R4 sleep accepted", {3'b0, mode_onehot}, {3'b0, M_SLP});
    rcr_nostop = 1'b0;
    bus_write(8'h0B, 4'b0001);

    // R8 write cannot set flags; R5 reserved with D3 set ignored
    bus_write(8'h0B, 4'b1111);
    check("R5 reserved 111", {3'b0, mode_onehot}, {3'b0, M_NRM});
    bus_read(8'h0B, rd, rv);
    check("R8 write no set", {4'b0, rd}, 8'h0);

    // R9 watchdog reset flag
    @(negedge clk); wd_reset_evt = 1'b1;
    @(negedge clk); wd_reset_evt = 1'b0;
    settle();
    bus_read(8'h0B, rd, rv);
    check("R9 wdrst latched", {4'b0, rd}, 8'h2);
    bus_read(8'h0B, rd, rv);
    check("R9 wdrst cleared", {4'b0, rd}, 8'h0);

    // R10 general failure from each fault, temperature warning
    for (int f = 0; f < 5; f++) begin
      faults = 5'b1 << f; settle();
      bus_read(8'h0B, rd, rv);
      check($sformatf("R10 gfail src%0d", f), {4'b0, rd}, 8'h8);
      faults = 5'b0; settle();
      bus_read(8'h0B, rd, rv);
      check($sformatf("R10 gfail gone%0d", f), {4'b0, rd}, 8'h0);
    end
    vdd_temp_warn = 1'b1; settle();
    bus_read(8'h0B, rd, rv);
    check("R10 vtemp", {4'b0, rd}, 8'h4);

    // R7 R5 other address
    bus_read(8'h0C, rd, rv);
    check("R7 other addr read", {4'b0, rd}, 8'h0);
    bus_write(8'h0C, 4'b0000);
    check("R5 other addr write", {3'b0, mode_onehot}, {3'b0, M_NRM});
    vdd_temp_warn = 1'b0; settle();

    // R11 back-pressure
    rcr_stop_wd = 1'b0;
    rsp_ready = 1'b0;
    @(negedge clk); wd_reset_evt = 1'b1;
    @(negedge clk); wd_reset_evt = 1'b0;
    settle();
    bus_read(8'h0B, rd, rv);
    check("R11 rsp valid", {7'b0, rv}, 8'd1);
    check("R11 rsp data", {4'b0, rd}, 8'h2);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h0B; req_wdata = 4'b0010;
    @(negedge clk);
    check("R11 ready low", {7'b0, req_ready}, 8'd0);
    check("R11 no effect", {3'b0, mode_onehot}, {3'b0, M_NRM});
    check("R11 data held", {4'b0, rsp_rdata}, 8'h2);
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    check("R11 write after release", {3'b0, mode_onehot}, {3'b0, M_STB});
    check("R11 rsp drained", {7'b0, rsp_valid}, 8'd0);

    // R1 external reset
    @(negedge clk); wd_reset_evt = 1'b1;
    @(negedge clk); wd_reset_evt = 1'b0;
    settle();
    ext_rst_n = 1'b0;
    @(negedge clk);
    ext_rst_n = 1'b1;
    @(negedge clk);
    check("R1 ext reset mode", {3'b0, mode_onehot}, {3'b0, M_NRM});
    bus_read(8'h0B, rd, rv);
    check("R1 ext reset flags", {4'b0, rd}, 8'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule